// File: doc/BRIEF.md
# Paged RAM bank-select mapper

This block maps the memory accesses of an 8-bit CPU onto a set of 64K RAM banks that sit on memory cards, with two cards in each pair. Software programs an 8-bit bank register by writing to an I/O port, address 0xFF by default. The register chooses one of two paging modes, a card pair, a bank inside that pair, and, in the 32K mode, which half of the bank appears in the upper half of the CPU address space.

For each memory request the block drives one active-low row select, one line for each 64K bank row. It also drives the RAM address bit 15 and an activity flag. The flag is high while the CPU works on any bank other than bank 0, which holds the main memory. Each pair has eight banks: the first card holds banks 0 to 3 and the second card holds banks 4 to 7. All outputs are combinational from the register, `mem_req` and `cpu_a15`. A register write is captured at the clock edge that ends the I/O write cycle.

Top module: `bank_mapper`

## Requirements
- R1: After reset the register is zero. A request then pulls only `row_sel_n[0]` low, `ram_a15` follows `cpu_a15`, and `activity` is low.
- R2: A clock edge with `io_wr` high and `io_addr` equal to the port loads `io_wdata` into the register, and the next access uses the new mapping. A write to any other port address has no effect.
- R3: With register bit 7 at 0 (64K mode), a request selects row index {bits 5:3, bits 2:0}, that is pair*8 + bank, and `ram_a15` equals `cpu_a15`.
- R4: Row line ordering is `row_sel_n[8*pair + 4*card + row]`, where card = bank bit 2 and row = bank bits 1:0. For example, bank 6 of pair 0 is card 1, row 2, which is line 6.
- R5: With bit 7 at 1 (32K mode) and `cpu_a15` low, a request selects row 0 and `ram_a15` is 0.
- R6: In 32K mode with `cpu_a15` high, a request selects the register's bank row, and `ram_a15` equals register bit 6.
- R7: With `mem_req` low, every row select is high and `activity` is low.
- R8: While `mem_req` is high, exactly one row select is low.
- R9: `activity` is high exactly when `mem_req` is high and `row_sel_n[0]` is high.
- R10: In 64K mode, register bit 6 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_req | input | 1 | Memory request active |
| cpu_a15 | input | 1 | CPU address bit 15 |
| row_sel_n | output | 8*N_PAIRS | Active-low bank row selects |
| ram_a15 | output | 1 | RAM address bit 15 |
| activity | output | 1 | High while a bank other than bank 0 is accessed |

## Verification
The hardest case to reach is the 32K mode with the upper half chosen. There the same register value gives bank 0 on a low-half access and a far bank with `ram_a15` high on a high-half access. The bench loads such a register value through the port and then toggles `cpu_a15` between consecutive requests. Through that one register value it checks the bank-0 fallback, the half bit and the activity flag. It also places a write to a neighbouring port between two checks, so that the ignored write shows at the row selects.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int CARD_ROWS  = 4;
  localparam int PAIR_BANKS = 2 * CARD_ROWS;
  localparam int BANK_W     = $clog2(PAIR_BANKS);
  localparam int PAIR_W     = 3;

  // Bit order matches the register: [7] mode, [6] half, [5:3] pair, [2:0] bank
  typedef struct packed {
    logic              mode32;
    logic              half_hi;
    logic [PAIR_W-1:0] pair;
    logic [BANK_W-1:0] bank;
  } bank_reg_t;
endpackage

// File: rtl/bank_reg.sv
module bank_reg
  import bank_map_pkg::*;
#(
  parameter logic [7:0] IO_PORT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output bank_reg_t  q
);
  logic hit;
  assign hit = io_wr && (io_addr == IO_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= bank_reg_t'(io_wdata);
  end
endmodule

// File: rtl/bank_route.sv
module bank_route
  import bank_map_pkg::*;
(
  input  bank_reg_t         q,
  input  logic              cpu_a15,
  output logic [PAIR_W-1:0] pair,
  output logic [BANK_W-1:0] bank,
  output logic              ram_a15
);
  always_comb begin
    if (q.mode32 && !cpu_a15) begin
      // low 32K of the CPU space stays on main memory
      pair    = '0;
      bank    = '0;
      ram_a15 = 1'b0;
    end else if (q.mode32) begin
      pair    = q.pair;
      bank    = q.bank;
      ram_a15 = q.half_hi;
    end else begin
      pair    = q.pair;
      bank    = q.bank;
      ram_a15 = cpu_a15;
    end
  end
endmodule

// File: rtl/row_decoder.sv
module row_decoder
  import bank_map_pkg::*;
#(
  parameter int N_PAIRS = 8
) (
  input  logic                         mem_req,
  input  logic [PAIR_W-1:0]            pair,
  input  logic [BANK_W-1:0]            bank,
  output logic [N_PAIRS*PAIR_BANKS-1:0] row_sel_n
);
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    logic pair_en;
    assign pair_en = mem_req && (pair == PAIR_W'(p));
    for (genvar c = 0; c < 2; c++) begin : g_card
      logic card_en;
      assign card_en = pair_en && (bank[BANK_W-1] == 1'(c));
      for (genvar r = 0; r < CARD_ROWS; r++) begin : g_row
        assign row_sel_n[p*PAIR_BANKS + c*CARD_ROWS + r] =
          ~(card_en && (bank[BANK_W-2:0] == (BANK_W-1)'(r)));
      end
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int         N_PAIRS = 8,
  parameter logic [7:0] IO_PORT = 8'hFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic [7:0]                    io_addr,
  input  logic [7:0]                    io_wdata,
  input  logic                          mem_req,
  input  logic                          cpu_a15,
  output logic [N_PAIRS*PAIR_BANKS-1:0] row_sel_n,
  output logic                          ram_a15,
  output logic                          activity
);
  bank_reg_t         q;
  logic [PAIR_W-1:0] pair;
  logic [BANK_W-1:0] bank;

  bank_reg #(.IO_PORT(IO_PORT)) u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .q(q)
  );

  bank_route u_route (
    .q(q), .cpu_a15(cpu_a15), .pair(pair), .bank(bank), .ram_a15(ram_a15)
  );

  row_decoder #(.N_PAIRS(N_PAIRS)) u_dec (
    .mem_req(mem_req), .pair(pair), .bank(bank), .row_sel_n(row_sel_n)
  );

  // bank-0 line high during a request means another bank is in use
  assign activity = mem_req && row_sel_n[0];
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int         N_PAIRS = 8,
  parameter logic [7:0] IO_PORT = 8'hFF
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   io_wr,
  input logic [7:0]             io_addr,
  input logic [7:0]             io_wdata,
  input logic                   mem_req,
  input logic                   cpu_a15,
  input logic [N_PAIRS*8-1:0]   row_sel_n,
  input logic                   ram_a15,
  input logic                   activity
);
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (&row_sel_n && !activity));

  assert_one_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(~row_sel_n) == 1));

  assert_act_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    activity |-> (mem_req && row_sel_n[0]));

  assert_act_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !activity) |-> !row_sel_n[0]);

  assert_full_a15_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_PORT && !io_wdata[7]) |=> (!mem_req || ram_a15 == cpu_a15));

  assert_low_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_PORT && io_wdata[7]) |=>
      (!(mem_req && !cpu_a15) || (!row_sel_n[0] && !ram_a15)));
endmodule

bind bank_mapper bank_mapper_chk #(.N_PAIRS(N_PAIRS), .IO_PORT(IO_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
  .mem_req(mem_req), .cpu_a15(cpu_a15), .row_sel_n(row_sel_n),
  .ram_a15(ram_a15), .activity(activity)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  localparam int NP = 8;
  localparam int NR = NP * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_wr = 1'b0;
  logic [7:0]    io_addr = '0;
  logic [7:0]    io_wdata = '0;
  logic          mem_req = 1'b0;
  logic          cpu_a15 = 1'b0;
  logic [NR-1:0] row_sel_n;
  logic          ram_a15;
  logic          activity;

  bank_mapper #(.N_PAIRS(NP), .IO_PORT(8'hFF)) uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mem_req(mem_req), .cpu_a15(cpu_a15),
    .row_sel_n(row_sel_n), .ram_a15(ram_a15), .activity(activity)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  logic [NR-1:0] q_rows[$];
  logic          q_a15[$];
  logic          q_act[$];
  string         q_tag[$];
  event          chk_ev;

  // Driver: write the bank register through a port, updating the model if it hits
  task automatic port_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    io_wr = 1'b1; io_addr = addr; io_wdata = data;
    @(negedge clk);
    io_wr = 1'b0;
    if (addr == 8'hFF) model = data;
  endtask

  // Driver: apply one access and push the expected outputs
  task automatic access(input logic req, input logic a15, input string tag);
    logic [NR-1:0] rows;
    logic          ea15;
    int            idx;
    @(negedge clk);
    mem_req = req; cpu_a15 = a15;
    rows = '1;
    if (model[7] && !a15) begin idx = 0; ea15 = 1'b0; end
    else begin idx = int'(model[5:3]) * 8 + int'(model[2:0]); ea15 = model[7] ? model[6] : a15; end
    if (req) rows[idx] = 1'b0;
    q_rows.push_back(rows);
    q_a15.push_back(ea15);
    q_act.push_back(req && idx != 0);
    q_tag.push_back(tag);
    #1 -> chk_ev;
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      @(chk_ev);
      while (q_rows.size() > 0) begin
        logic [NR-1:0] er;
        logic ea, ec;
        string t;
        er = q_rows.pop_front(); ea = q_a15.pop_front();
        ec = q_act.pop_front(); t = q_tag.pop_front();
        tests++;
        if (row_sel_n !== er || ram_a15 !== ea || activity !== ec) begin
          fails++;
          $display("FAIL %s: rows=%h a15=%b act=%b expected rows=%h a15=%b act=%b",
                   t, row_sel_n, ram_a15, activity, er, ea, ec);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(1'b1, 1'b0, "R1 reset bank 0");
    access(1'b1, 1'b1, "R1 reset a15 follows");
    access(1'b0, 1'b1, "R7 idle all high");
    port_write(8'hFF, 8'h06);
    access(1'b1, 1'b0, "R4 bank 6 is card 1 row 2");
    access(1'b1, 1'b1, "R9 activity off main");
    port_write(8'hFF, 8'h2B);
    access(1'b1, 1'b0, "R3 pair 5 bank 3");
    port_write(8'hFE, 8'h01);
    access(1'b1, 1'b1, "R2 other port ignored");
    port_write(8'hFF, 8'h46);
    access(1'b1, 1'b0, "R10 half bit ignored in 64K low");
    access(1'b1, 1'b1, "R10 half bit ignored in 64K high");
    port_write(8'hFF, 8'hC9);
    access(1'b1, 1'b0, "R5 32K low half to bank 0");
    access(1'b1, 1'b1, "R6 32K upper half bit set");
    access(1'b0, 1'b1, "R7 idle in 32K");
    port_write(8'hFF, 8'h89);
    access(1'b1, 1'b1, "R6 32K lower half bit clear");
    port_write(8'hFF, 8'hBF);
    access(1'b1, 1'b1, "R8 last row pair 7");
    port_write(8'hFF, 8'h00);
    access(1'b1, 1'b1, "R2 rewrite back to bank 0");
    access(1'b1, 1'b0, "R9 main memory no activity");
    for (int k = 0; k < 64; k++) begin
      port_write(8'hFF, 8'(k));
      access(1'b1, 1'(k % 2), "R3 sweep all rows");
    end
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule